// File: doc/BRIEF.md
# Segmented Data Address Router

This block sits between a 16-bit processor core and the data-side memory fabric. For every data access the core presents, it works out which of four targets the access belongs to: on-chip RAM, external memory, the internal special-function-register (SFR) hardware, or the external SFR space. It then raises exactly one select strobe for that target. It also forms the address the target should see and steers the write data onto little-endian byte lanes. The routing decision depends on three things: the addressing mode of the access (direct, indirect or explicit-external), the offset, and whether the chosen segment register is zero.

A direct access reaches an 11-bit, 2 KB window whose upper half is always SFR space. The lower half of that window, like the lower 2 KB of indirect space, means on-chip RAM only while the segment register is zero. When the segment is non-zero, those addresses mean external memory. An explicit-external access ignores the on-chip overlap entirely. Word accesses are forced onto even addresses.

Every request is accepted in one clock. The strobe, address, lane enables and lane data are registered and appear one cycle after the request.

Top module: `seg_addr_router`

## Requirements
- R1: While `rst_n` is low at a rising edge, all four strobes, `wr_out`, `lane_en`, `addr_out` and `lane_wdata` become zero, even if a request is presented.
- R2: When `req_valid` is low, or `req_mode` is 3 (reserved), no strobe is raised, `lane_en` is 0 and `wr_out` is 0 in the following cycle.
- R3: A direct access (`req_mode` = 0) uses offset bits [10:0] as its direct address and ignores the higher offset bits. Direct address 0x400–0x5FF raises `sel_isfr`, and 0x600–0x7FF raises `sel_xsfr`, whatever the segment registers hold.
- R4: A direct access below 0x400 raises `sel_iram` when the selected segment is zero, and `sel_xmem` otherwise.
- R5: An indirect access (`req_mode` = 1) with an aligned offset below 0x800 raises `sel_iram` when the selected segment is zero. Every other indirect access raises `sel_xmem`. An indirect access never raises an SFR strobe.
- R6: An explicit-external access (`req_mode` = 2) always raises `sel_xmem`.
- R7: The selected segment is `es_reg` when `req_es` is 1, and `ds_reg` otherwise. `addr_out[23:16]` is that segment for a `sel_xmem` access and zero for other targets. `addr_out[15:0]` is the aligned offset, except for direct accesses, where it is the zero-extended 11-bit direct address.
- R8: When `req_word` is 1, offset bit 0 is treated as zero for both routing and `addr_out`.
- R9: Bit 0 of `lane_en` and `lane_wdata` is the even byte, and bit 1 is the odd byte. A word access gives `lane_en` = 2'b11 and `lane_wdata` = `req_wdata`. A byte access gives `lane_en` = 2'b01 at an even offset and 2'b10 at an odd offset, with `req_wdata[7:0]` copied onto both lanes.
- R10: Every valid request in modes 0–2 raises exactly one strobe one cycle later, with `wr_out` equal to `req_write`. At no time is more than one strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | An access is presented this cycle |
| req_mode | input | 2 | 0 direct, 1 indirect, 2 explicit-external, 3 reserved |
| req_word | input | 1 | 1 word access, 0 byte access |
| req_write | input | 1 | 1 write, 0 read |
| req_es | input | 1 | Use extra segment instead of data segment |
| req_off | input | 16 | Access offset |
| ds_reg | input | 8 | Data segment register |
| es_reg | input | 8 | Extra segment register |
| req_wdata | input | 16 | Write data, low byte in [7:0] |
| sel_iram | output | 1 | On-chip RAM select |
| sel_xmem | output | 1 | External memory select |
| sel_isfr | output | 1 | Internal SFR select |
| sel_xsfr | output | 1 | External SFR select |
| wr_out | output | 1 | Write qualifier for the selected target |
| addr_out | output | 24 | Target address, segment in [23:16] for external memory |
| lane_en | output | 2 | Byte lane enables |
| lane_wdata | output | 16 | Lane-ordered write data |

## Verification
The hardest case to reach is a word access at an odd offset that lands exactly on a region edge. For example, 0x3FF, 0x5FF or 0x7FF can only route correctly after alignment has pulled them below the boundary. A related hard case is a direct offset whose upper bits are set but must be ignored. The stimulus sweeps a fixed set of boundary offsets and a spread of scattered offsets through every mode, both sizes and both segment selects. It does this for segment pairs in which only one of the two registers is zero, so choosing the wrong register visibly changes the target. Idle cycles are interleaved so the return to no strobe is seen between live requests.

// File: rtl/seg_rt_pkg.sv
// Shared types for the segmented data address router.
// Assumes a two-bit addressing-mode field from the core.
package seg_rt_pkg;

    // Addressing mode carried by each request
    typedef enum logic [1:0] {
        AM_DIRECT   = 2'd0,
        AM_INDIRECT = 2'd1,
        AM_FAR      = 2'd2,
        AM_RSVD     = 2'd3
    } amode_e;

    // Routing result: which target owns the access
    typedef enum logic [2:0] {
        TG_NONE = 3'd0,
        TG_IRAM = 3'd1,
        TG_XMEM = 3'd2,
        TG_ISFR = 3'd3,
        TG_XSFR = 3'd4
    } tgt_e;

endpackage

// File: rtl/seg_rt_segsel.sv
// Segment selection: picks the data or extra segment for a request and
// reports whether the chosen one is zero. Purely combinational.
module seg_rt_segsel #(
    parameter int SEG_W = 8
) (
    input  logic             use_es,
    input  logic [SEG_W-1:0] ds_val,
    input  logic [SEG_W-1:0] es_val,
    output logic [SEG_W-1:0] seg,
    output logic             seg_zero
);

    // Choose segment and flag the zero case that enables on-chip space
    always_comb begin
        seg      = use_es ? es_val : ds_val;
        seg_zero = (seg == '0);
    end

endmodule

// File: rtl/seg_rt_lanes.sv
// Alignment and byte-lane steering. Word accesses clear the low offset
// bits and enable all lanes; byte accesses enable the one lane the offset
// names and copy the low data byte onto every lane.
// Assumes DATA_W is a power-of-two multiple of 8 with at least two lanes.
module seg_rt_lanes #(
    parameter int OFS_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              word,
    input  logic [OFS_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [OFS_W-1:0]  eff_off,
    output logic [DATA_W/8-1:0] lane_en,
    output logic [DATA_W-1:0] lane_wdata
);

    localparam int LANES = DATA_W / 8;
    localparam int LSW   = $clog2(LANES);

    logic [LSW-1:0] byte_idx;

    // Force word accesses onto a lane-aligned offset
    always_comb begin
        byte_idx = off[LSW-1:0];
        eff_off  = word ? {off[OFS_W-1:LSW], {LSW{1'b0}}} : off;
    end

    // One enable and one data byte per lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_en[g]          = word | (byte_idx == LSW'(g));
        assign lane_wdata[8*g +: 8] = word ? wdata[8*g +: 8] : wdata[7:0];
    end

endmodule

// File: rtl/seg_rt_decode.sv
// Target decode. Maps addressing mode, aligned offset and the segment-zero
// flag to one target, and yields the offset the target should see.
// Assumes DIR_W <= OFS_W and ISFR_LO < XSFR_LO < 2**DIR_W.
module seg_rt_decode
    import seg_rt_pkg::*;
#(
    parameter int OFS_W      = 16,
    parameter int DIR_W      = 11,
    parameter int IRAM_BYTES = 2048,
    parameter int ISFR_LO    = 1024,
    parameter int XSFR_LO    = 1536
) (
    input  logic             valid,
    input  amode_e           mode,
    input  logic [OFS_W-1:0] eff_off,
    input  logic             seg_zero,
    output tgt_e             tgt,
    output logic [OFS_W-1:0] tgt_off
);

    localparam logic [DIR_W-1:0] ISFR_LO_V = DIR_W'(ISFR_LO);
    localparam logic [DIR_W-1:0] XSFR_LO_V = DIR_W'(XSFR_LO);
    localparam logic [OFS_W:0]   IRAM_LIM  = (OFS_W + 1)'(IRAM_BYTES);

    logic [DIR_W-1:0] dir;
    logic             below_iram;

    // Direct address and on-chip window test
    always_comb begin
        dir        = eff_off[DIR_W-1:0];
        below_iram = ({1'b0, eff_off} < IRAM_LIM);
    end

    // Pick the owning target for the current request
    always_comb begin
        tgt     = TG_NONE;
        tgt_off = eff_off;
        if (valid) begin
            unique case (mode)
                AM_DIRECT: begin
                    tgt_off = {{(OFS_W - DIR_W){1'b0}}, dir};
                    if (dir >= XSFR_LO_V)      tgt = TG_XSFR;
                    else if (dir >= ISFR_LO_V) tgt = TG_ISFR;
                    else if (seg_zero)         tgt = TG_IRAM;
                    else                       tgt = TG_XMEM;
                end
                AM_INDIRECT: tgt = (below_iram && seg_zero) ? TG_IRAM : TG_XMEM;
                AM_FAR:      tgt = TG_XMEM;
                default:     tgt = TG_NONE;
            endcase
        end
    end

endmodule

// File: rtl/seg_addr_router.sv
// Segmented data address router (top). Combines segment selection, lane
// steering and target decode, then registers one strobe, the target
// address and the lane outputs so they appear one cycle after the request.
// Assumes the targets sample the outputs in the cycle they are presented.
module seg_addr_router
    import seg_rt_pkg::*;
#(
    parameter int OFS_W      = 16,
    parameter int SEG_W      = 8,
    parameter int DATA_W     = 16,
    parameter int DIR_W      = 11,
    parameter int IRAM_BYTES = 2048,
    parameter int ISFR_LO    = 1024,
    parameter int XSFR_LO    = 1536
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [1:0]                req_mode,
    input  logic                      req_word,
    input  logic                      req_write,
    input  logic                      req_es,
    input  logic [OFS_W-1:0]          req_off,
    input  logic [SEG_W-1:0]          ds_reg,
    input  logic [SEG_W-1:0]          es_reg,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      sel_iram,
    output logic                      sel_xmem,
    output logic                      sel_isfr,
    output logic                      sel_xsfr,
    output logic                      wr_out,
    output logic [SEG_W+OFS_W-1:0]    addr_out,
    output logic [DATA_W/8-1:0]       lane_en,
    output logic [DATA_W-1:0]         lane_wdata
);

    localparam int ADDR_W = SEG_W + OFS_W;
    localparam int LANES  = DATA_W / 8;

    logic [SEG_W-1:0]  seg;
    logic              seg_zero;
    logic [OFS_W-1:0]  eff_off;
    logic [LANES-1:0]  lane_en_c;
    logic [DATA_W-1:0] lane_wdata_c;
    tgt_e              tgt;
    logic [OFS_W-1:0]  tgt_off;
    logic [3:0]        sel_c;
    logic [ADDR_W-1:0] addr_c;

    seg_rt_segsel #(.SEG_W(SEG_W)) u_seg (
        .use_es   (req_es),
        .ds_val   (ds_reg),
        .es_val   (es_reg),
        .seg      (seg),
        .seg_zero (seg_zero)
    );

    seg_rt_lanes #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_lanes (
        .word       (req_word),
        .off        (req_off),
        .wdata      (req_wdata),
        .eff_off    (eff_off),
        .lane_en    (lane_en_c),
        .lane_wdata (lane_wdata_c)
    );

    seg_rt_decode #(
        .OFS_W(OFS_W), .DIR_W(DIR_W), .IRAM_BYTES(IRAM_BYTES),
        .ISFR_LO(ISFR_LO), .XSFR_LO(XSFR_LO)
    ) u_dec (
        .valid    (req_valid),
        .mode     (amode_e'(req_mode)),
        .eff_off  (eff_off),
        .seg_zero (seg_zero),
        .tgt      (tgt),
        .tgt_off  (tgt_off)
    );

    // Turn the target code into strobes {xsfr, isfr, xmem, iram}
    always_comb begin
        sel_c = 4'b0000;
        unique case (tgt)
            TG_IRAM: sel_c = 4'b0001;
            TG_XMEM: sel_c = 4'b0010;
            TG_ISFR: sel_c = 4'b0100;
            TG_XSFR: sel_c = 4'b1000;
            default: sel_c = 4'b0000;
        endcase
    end

    // Segment goes on the upper address bits only for external memory
    always_comb begin
        addr_c = {(tgt == TG_XMEM) ? seg : {SEG_W{1'b0}}, tgt_off};
    end

    // Output register stage; idle cycles drop strobes and enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {sel_xsfr, sel_isfr, sel_xmem, sel_iram} <= 4'b0000;
            wr_out     <= 1'b0;
            addr_out   <= '0;
            lane_en    <= '0;
            lane_wdata <= '0;
        end else if (tgt != TG_NONE) begin
            {sel_xsfr, sel_isfr, sel_xmem, sel_iram} <= sel_c;
            wr_out     <= req_write;
            addr_out   <= addr_c;
            lane_en    <= lane_en_c;
            lane_wdata <= lane_wdata_c;
        end else begin
            {sel_xsfr, sel_isfr, sel_xmem, sel_iram} <= 4'b0000;
            wr_out     <= 1'b0;
            lane_en    <= '0;
        end
    end

endmodule

// File: rtl/seg_rt_chk.sv
// Property checker for the router, attached to every instance by bind.
// Assumes the default 16-bit offset, 8-bit segment and two-lane shape.
module seg_rt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_mode,
    input logic        req_word,
    input logic        sel_iram,
    input logic        sel_xmem,
    input logic        sel_isfr,
    input logic        sel_xsfr,
    input logic [23:0] addr_out,
    input logic [1:0]  lane_en
);

    logic [3:0] sels;
    assign sels = {sel_xsfr, sel_isfr, sel_xmem, sel_iram};

    // R10: never two targets at once
    a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sels));

    // R10: a live request yields exactly one strobe next cycle
    a_r10_live_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode != 2'd3) |=> ($countones(sels) == 1));

    // R2: idle yields no strobe and no lane
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_mode == 2'd3) |=> (sels == 4'b0000 && lane_en == 2'b00));

    // R5: indirect never reaches SFR space
    a_r5_no_sfr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'd1) |=> (!sel_isfr && !sel_xsfr));

    // R6: explicit-external always lands on external memory
    a_r6_far_xmem: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'd2) |=> sel_xmem);

    // R8: word accesses leave an even address and both lanes
    a_r8_word_even: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode != 2'd3 && req_word) |=> (!addr_out[0] && lane_en == 2'b11));

    // R7: only external memory carries a segment byte
    a_r7_seg_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_iram || sel_isfr || sel_xsfr) |-> (addr_out[23:16] == 8'h00));

endmodule

bind seg_addr_router seg_rt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .req_word  (req_word),
    .sel_iram  (sel_iram),
    .sel_xmem  (sel_xmem),
    .sel_isfr  (sel_isfr),
    .sel_xsfr  (sel_xsfr),
    .addr_out  (addr_out),
    .lane_en   (lane_en)
);

// File: tb/sim_seg_addr_router.sv
// Sweep bench for the segmented data address router.
module sim_seg_addr_router;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_word, req_write, req_es;
    logic [1:0]  req_mode;
    logic [15:0] req_off, req_wdata;
    logic [7:0]  ds_reg, es_reg;
    logic        sel_iram, sel_xmem, sel_isfr, sel_xsfr, wr_out;
    logic [23:0] addr_out;
    logic [1:0]  lane_en;
    logic [15:0] lane_wdata;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    seg_addr_router u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_word(req_word), .req_write(req_write), .req_es(req_es),
        .req_off(req_off), .ds_reg(ds_reg), .es_reg(es_reg), .req_wdata(req_wdata),
        .sel_iram(sel_iram), .sel_xmem(sel_xmem), .sel_isfr(sel_isfr),
        .sel_xsfr(sel_xsfr), .wr_out(wr_out), .addr_out(addr_out),
        .lane_en(lane_en), .lane_wdata(lane_wdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (mode %0d word %0d es %0d off %h)",
                     tag, act, exp, req_mode, req_word, req_es, req_off);
        end
    endtask

    function automatic logic [15:0] edge_off(input int k);
        case (k)
            0: return 16'h0000;   1: return 16'h0001;   2: return 16'h03FE;
            3: return 16'h03FF;   4: return 16'h0400;   5: return 16'h0401;
            6: return 16'h05FF;   7: return 16'h0600;   8: return 16'h0601;
            9: return 16'h07FE;  10: return 16'h07FF;  11: return 16'h0800;
           12: return 16'h0801;  13: return 16'hFC00;  14: return 16'hFDFF;
           default: return 16'hFFFF;
        endcase
    endfunction

    // Drive one request at a falling edge, then check at the next falling edge
    task automatic apply(input logic v, input logic [1:0] m, input logic w,
                         input logic wr, input logic e, input logic [15:0] off,
                         input logic [7:0] ds, input logic [7:0] es,
                         input logic [15:0] wd);
        logic [7:0]  seg;
        logic [15:0] eo, ofs;
        logic [10:0] dir;
        logic [3:0]  exp_sel;
        logic [1:0]  exp_len;
        string       tag;
        req_valid = v; req_mode = m; req_word = w; req_write = wr; req_es = e;
        req_off = off; ds_reg = ds; es_reg = es; req_wdata = wd;
        seg = e ? es : ds;
        eo  = w ? {off[15:1], 1'b0} : off;
        dir = eo[10:0];
        ofs = eo;
        exp_sel = 4'b0000;
        tag = "R2";
        case (m)
            2'd0: begin
                ofs = {5'b0, dir};
                if (dir >= 11'h600)      begin exp_sel = 4'b1000; tag = "R3 xsfr"; end
                else if (dir >= 11'h400) begin exp_sel = 4'b0100; tag = "R3 isfr"; end
                else if (seg == 8'h00)   begin exp_sel = 4'b0001; tag = "R4 iram"; end
                else                     begin exp_sel = 4'b0010; tag = "R4 xmem"; end
            end
            2'd1: begin
                exp_sel = (eo < 16'h0800 && seg == 8'h00) ? 4'b0001 : 4'b0010;
                tag = "R5 indirect";
            end
            2'd2: begin exp_sel = 4'b0010; tag = "R6 far"; end
            default: exp_sel = 4'b0000;
        endcase
        if (!v) begin exp_sel = 4'b0000; tag = "R2"; end
        exp_len = w ? 2'b11 : (off[0] ? 2'b10 : 2'b01);
        @(negedge clk);
        check(tag, {28'd0, sel_xsfr, sel_isfr, sel_xmem, sel_iram}, {28'd0, exp_sel});
        if (exp_sel == 4'b0000) begin
            check("R2 lanes", {30'd0, lane_en}, 32'd0);
            check("R2 wr", {31'd0, wr_out}, 32'd0);
        end else begin
            check(w ? "R8 addr" : "R7 addr", {8'd0, addr_out},
                  {8'd0, (exp_sel == 4'b0010) ? seg : 8'h00, ofs});
            check("R9 lane_en", {30'd0, lane_en}, {30'd0, exp_len});
            check("R9 lane_wdata", {16'd0, lane_wdata},
                  {16'd0, w ? wd : {wd[7:0], wd[7:0]}});
            check("R10 wr", {31'd0, wr_out}, {31'd0, wr});
        end
    endtask

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b1; req_mode = 2'd2; req_word = 1'b1; req_write = 1'b1;
        req_es = 1'b0; req_off = 16'h1234; ds_reg = 8'h77; es_reg = 8'h00;
        req_wdata = 16'hBEEF;
        repeat (3) @(negedge clk);
        // R1: reset dominates a live request
        check("R1 strobes", {28'd0, sel_xsfr, sel_isfr, sel_xmem, sel_iram}, 32'd0);
        check("R1 addr", {8'd0, addr_out}, 32'd0);
        check("R1 lanes", {30'd0, lane_en}, 32'd0);
        check("R1 wdata", {16'd0, lane_wdata}, 32'd0);
        check("R1 wr", {31'd0, wr_out}, 32'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        for (int sc = 0; sc < 3; sc++) begin
            for (int m = 0; m < 4; m++) begin
                for (int w = 0; w < 2; w++) begin
                    for (int e = 0; e < 2; e++) begin
                        for (int k = 0; k < 300; k++) begin
                            logic [7:0]  ds, es;
                            logic [15:0] off, wd;
                            logic        v;
                            ds  = (sc == 2) ? 8'h3C : 8'h00;
                            es  = (sc == 1) ? 8'h5A : 8'h00;
                            off = (k < 16) ? edge_off(k) : 16'(k * 211 + sc * 7);
                            wd  = 16'(k * 40503 + m * 4099 + w * 17 + e);
                            v   = (k % 7) != 3;
                            apply(v, 2'(m), w[0], off[1] ^ w[0], e[0], off, ds, es, wd);
                        end
                    end
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule